// File: doc/BRIEF.md
# Shifter Operand Generation Unit

This combinational unit builds the second ALU operand of a 32-bit data-processing datapath, together with the carry that the shifter produces. The operand comes from one of three sources. The first is an 8-bit constant rotated right by an even amount. The second is a register value shifted by a 5-bit amount taken from the instruction. The third is a register value shifted by an amount held in the low byte of a second register. The register file and the instruction decoder lie outside the block. They supply the register values, the immediate fields and the current carry flag.

A plain barrel shifter does not cover every case. An amount field of zero in the instruction selects a special meaning that depends on the shift kind: pass-through, a full 32-bit shift, or rotate-right-extended. Register amounts of 32 or more also have fixed results and carries. The unit sorts each request into one of these classes before it forms the result, so that every encoding yields a defined operand and carry.

Top module: `opnd_shift_unit`

## Requirements
- R1: With `form_sel` = 00 (immediate rotate), `operand_out` is `imm_byte` zero-extended to 32 bits and rotated right by twice `imm_rot`.
- R2: With `form_sel` = 00, `carry_out` equals `carry_in` when `imm_rot` is 0 and equals bit 31 of `operand_out` otherwise.
- R3: For a shift amount n from 1 to 31, in either shift form, `shift_kind` 00 (logical left) gives `rm_val << n` with carry `rm_val[32-n]`. Kind 01 (logical right), kind 10 (arithmetic right) and kind 11 (rotate right) give the matching shift of `rm_val`, with carry `rm_val[n-1]`.
- R4: With `form_sel` = 01 (immediate shift), kind 00 and `imm_shamt` = 0, `operand_out` equals `rm_val` and `carry_out` equals `carry_in`.
- R5: With `form_sel` = 01, kind 01 and `imm_shamt` = 0, the unit shifts by 32: `operand_out` is 0 and `carry_out` is `rm_val[31]`.
- R6: With `form_sel` = 01, kind 10 and `imm_shamt` = 0, `operand_out` has every bit equal to `rm_val[31]` and `carry_out` is `rm_val[31]`.
- R7: With `form_sel` = 01, kind 11 and `imm_shamt` = 0, `operand_out` is `{carry_in, rm_val[31:1]}` and `carry_out` is `rm_val[0]`.
- R8: With `form_sel` = 10 (register shift), only `rs_val[7:0]` sets the amount, and bits 31:8 have no effect. An amount of 0 passes `rm_val` through with `carry_out` = `carry_in`.
- R9: With `form_sel` = 10 and kind 00, an amount of exactly 32 gives 0 with carry `rm_val[0]`. Amounts from 33 to 255 give 0 with carry 0.
- R10: With `form_sel` = 10 and kind 01, an amount of exactly 32 gives 0 with carry `rm_val[31]`. Amounts from 33 to 255 give 0 with carry 0.
- R11: With `form_sel` = 10 and kind 10, any amount of 32 or more gives every bit equal to `rm_val[31]`, with carry `rm_val[31]`.
- R12: With `form_sel` = 10 and kind 11, a nonzero `rs_val[7:0]` whose bits 4:0 are zero gives `rm_val` with carry `rm_val[31]`. Any other nonzero amount rotates by `rs_val[4:0]`.
- R13: With `form_sel` = 11 (unused code), `operand_out` is 0 and `carry_out` equals `carry_in`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| form_sel | input | 2 | Operand source: 00 immediate rotate, 01 immediate shift, 10 register shift, 11 unused |
| shift_kind | input | 2 | 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right |
| imm_byte | input | 8 | Constant for the immediate-rotate form |
| imm_rot | input | 4 | Half of the rotate amount for the constant |
| imm_shamt | input | 5 | Shift amount for the immediate-shift form |
| rm_val | input | 32 | Value to be shifted |
| rs_val | input | 32 | Register holding the shift amount in bits 7:0 |
| carry_in | input | 1 | Current carry flag |
| operand_out | output | 32 | Generated operand |
| carry_out | output | 1 | Shifter carry-out |

## Verification
The bench targets every boundary of the amount encoding: a zero field for each shift kind, register amounts of 31, 32, 33 and 255, and rotate amounts that are nonzero multiples of 32. A unit that treated a zero immediate field as a plain zero shift would pass `rm_val` through where zeros, sign fill or a rotate-right-extended value are due. A unit that reduced register amounts modulo 32 would return `rm_val` or a partial shift where zero is due. An off-by-one carry tap shows up as a wrong carry at n = 1 and n = 31. The bench also sweeps every amount from 0 to 40, plus 255, for all four kinds against an arithmetic model.

// File: rtl/opnd_pkg.sv
// Shared types for the shifter operand generation unit.
// Assumes the encodings listed in the brief; nothing here holds state.
package opnd_pkg;

    typedef enum logic [1:0] {
        FORM_IMM_ROT   = 2'b00,
        FORM_IMM_SHIFT = 2'b01,
        FORM_REG_SHIFT = 2'b10,
        FORM_NONE      = 2'b11
    } opnd_form_e;

    typedef enum logic [1:0] {
        SK_LSL = 2'b00,
        SK_LSR = 2'b01,
        SK_ASR = 2'b10,
        SK_ROR = 2'b11
    } shift_kind_e;

    // Amount classes: pass-through, partial 1..W-1, exactly W, beyond W, rotate-extended
    typedef enum logic [2:0] {
        AC_PASS   = 3'd0,
        AC_PART   = 3'd1,
        AC_FULL   = 3'd2,
        AC_BEYOND = 3'd3,
        AC_RRX    = 3'd4
    } amt_class_e;

endpackage

// File: rtl/opnd_imm_rotator.sv
// Rotates a zero-extended immediate constant right by twice the rotate field.
// Assumes DATA_W is at least IMM_W and at least 2**(ROT_W+1).
module opnd_imm_rotator #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 8,
    parameter int ROT_W  = 4
) (
    input  logic [IMM_W-1:0]  imm_byte,
    input  logic [ROT_W-1:0]  imm_rot,
    input  logic              carry_in,
    output logic [DATA_W-1:0] rot_res,
    output logic              rot_cout
);

    localparam int PAD_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] stage [ROT_W+1];

    // Zero-extend the constant into the first stage
    assign stage[0] = {{PAD_W{1'b0}}, imm_byte};

    // One rotate stage per rotate-field bit, stage k moves by 2**(k+1)
    for (genvar k = 0; k < ROT_W; k++) begin : g_rot
        localparam int STEP = 2 << k;
        assign stage[k+1] = imm_rot[k]
                          ? {stage[k][STEP-1:0], stage[k][DATA_W-1:STEP]}
                          : stage[k];
    end

    assign rot_res = stage[ROT_W];

    // Carry: keep the flag on a zero rotate, else the result's top bit
    always_comb begin
        if (imm_rot == '0) rot_cout = carry_in;
        else               rot_cout = rot_res[DATA_W-1];
    end

endmodule

// File: rtl/opnd_amt_decode.sv
// Classifies the shift amount of either shift form into pass, partial,
// full-width, beyond-width or rotate-extended, and gives the partial amount.
// Assumes the register amount field is wide enough to hold DATA_W.
module opnd_amt_decode
    import opnd_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int SHAMT_W  = 5,
    parameter int RS_AMT_W = 8
) (
    input  logic                is_reg,
    input  shift_kind_e         kind,
    input  logic [SHAMT_W-1:0]  imm_shamt,
    input  logic [RS_AMT_W-1:0] rs_low,
    output amt_class_e          amt_class,
    output logic [SHAMT_W-1:0]  amt
);

    localparam logic [RS_AMT_W-1:0] FULL_AMT = RS_AMT_W'(DATA_W);

    // Pick the amount source and sort it into a class
    always_comb begin
        amt_class = AC_PASS;
        amt       = '0;
        if (!is_reg) begin
            amt = imm_shamt;
            if (imm_shamt != '0) begin
                amt_class = AC_PART;
            end else begin
                case (kind)
                    SK_LSL:  amt_class = AC_PASS;
                    SK_ROR:  amt_class = AC_RRX;
                    default: amt_class = AC_FULL;
                endcase
            end
        end else begin
            amt = rs_low[SHAMT_W-1:0];
            if (rs_low == '0) begin
                amt_class = AC_PASS;
            end else begin
                case (kind)
                    SK_ROR: begin
                        if (rs_low[SHAMT_W-1:0] == '0) amt_class = AC_FULL;
                        else                           amt_class = AC_PART;
                    end
                    SK_ASR: begin
                        if (rs_low >= FULL_AMT) amt_class = AC_FULL;
                        else                    amt_class = AC_PART;
                    end
                    default: begin
                        if (rs_low < FULL_AMT)       amt_class = AC_PART;
                        else if (rs_low == FULL_AMT) amt_class = AC_FULL;
                        else                         amt_class = AC_BEYOND;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/opnd_barrel.sv
// Log-stage shifter for all four shift kinds, with the fixed results of the
// pass, full-width, beyond-width and rotate-extended classes.
// Left shifts reuse the right shifter on a bit-reversed value.
module opnd_barrel
    import opnd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  shift_kind_e                 kind,
    input  amt_class_e                  amt_class,
    input  logic [$clog2(DATA_W)-1:0]   amt,
    input  logic [DATA_W-1:0]           val,
    input  logic                        carry_in,
    output logic [DATA_W-1:0]           sh_res,
    output logic                        sh_cout
);

    localparam int SHAMT_W = $clog2(DATA_W);
    localparam int MSB     = DATA_W - 1;

    logic [DATA_W-1:0]  val_rev;
    logic [DATA_W-1:0]  stage [SHAMT_W+1];
    logic [DATA_W-1:0]  part_rev;
    logic [DATA_W-1:0]  part_res;
    logic [SHAMT_W-1:0] tap_idx;
    logic               fill;
    logic               is_rot;
    logic               is_left;
    logic               part_c;

    // Bit-reverse the input so a left shift becomes a right shift
    always_comb begin
        for (int i = 0; i < DATA_W; i++) val_rev[i] = val[MSB-i];
    end

    assign is_left  = (kind == SK_LSL);
    assign is_rot   = (kind == SK_ROR);
    assign fill     = (kind == SK_ASR) ? val[MSB] : 1'b0;
    assign stage[0] = is_left ? val_rev : val;

    // Right-shift stages, stage k moves by 2**k with fill or wrap
    for (genvar k = 0; k < SHAMT_W; k++) begin : g_sh
        localparam int STEP = 1 << k;
        assign stage[k+1] = amt[k]
                          ? {(is_rot ? stage[k][STEP-1:0] : {STEP{fill}}),
                             stage[k][DATA_W-1:STEP]}
                          : stage[k];
    end

    // Undo the reversal for left shifts
    always_comb begin
        for (int i = 0; i < DATA_W; i++) part_rev[i] = stage[SHAMT_W][MSB-i];
    end

    assign part_res = is_left ? part_rev : stage[SHAMT_W];

    // Last bit shifted out: same tap index on the (possibly reversed) source
    assign tap_idx = amt - 1'b1;
    assign part_c  = stage[0][tap_idx];

    // Select the result and carry by amount class
    always_comb begin
        sh_res  = val;
        sh_cout = carry_in;
        case (amt_class)
            AC_PASS: begin
                sh_res  = val;
                sh_cout = carry_in;
            end
            AC_PART: begin
                sh_res  = part_res;
                sh_cout = part_c;
            end
            AC_FULL: begin
                case (kind)
                    SK_LSL: begin
                        sh_res  = '0;
                        sh_cout = val[0];
                    end
                    SK_LSR: begin
                        sh_res  = '0;
                        sh_cout = val[MSB];
                    end
                    SK_ASR: begin
                        sh_res  = {DATA_W{val[MSB]}};
                        sh_cout = val[MSB];
                    end
                    default: begin
                        sh_res  = val;
                        sh_cout = val[MSB];
                    end
                endcase
            end
            AC_BEYOND: begin
                if (kind == SK_ASR) begin
                    sh_res  = {DATA_W{val[MSB]}};
                    sh_cout = val[MSB];
                end else begin
                    sh_res  = '0;
                    sh_cout = 1'b0;
                end
            end
            AC_RRX: begin
                sh_res  = {carry_in, val[MSB:1]};
                sh_cout = val[0];
            end
            default: begin
                sh_res  = val;
                sh_cout = carry_in;
            end
        endcase
    end

endmodule

// File: rtl/opnd_shift_unit.sv
// Top of the shifter operand generation unit. Purely combinational: selects
// among the rotated immediate, the immediate-amount shift and the
// register-amount shift, and drives the operand and shifter carry.
// Assumes the register and immediate fields are stable while in use.
module opnd_shift_unit
    import opnd_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int IMM_W    = 8,
    parameter int ROT_W    = 4,
    parameter int RS_AMT_W = 8
) (
    input  logic [1:0]                  form_sel,
    input  logic [1:0]                  shift_kind,
    input  logic [IMM_W-1:0]            imm_byte,
    input  logic [ROT_W-1:0]            imm_rot,
    input  logic [$clog2(DATA_W)-1:0]   imm_shamt,
    input  logic [DATA_W-1:0]           rm_val,
    input  logic [DATA_W-1:0]           rs_val,
    input  logic                        carry_in,
    output logic [DATA_W-1:0]           operand_out,
    output logic                        carry_out
);

    localparam int SHAMT_W = $clog2(DATA_W);

    opnd_form_e          form;
    shift_kind_e         kind;
    amt_class_e          amt_class;
    logic [SHAMT_W-1:0]  amt;
    logic [DATA_W-1:0]   rot_res;
    logic                rot_cout;
    logic [DATA_W-1:0]   sh_res;
    logic                sh_cout;

    assign form = opnd_form_e'(form_sel);
    assign kind = shift_kind_e'(shift_kind);

    opnd_imm_rotator #(
        .DATA_W (DATA_W),
        .IMM_W  (IMM_W),
        .ROT_W  (ROT_W)
    ) u_rot (
        .imm_byte (imm_byte),
        .imm_rot  (imm_rot),
        .carry_in (carry_in),
        .rot_res  (rot_res),
        .rot_cout (rot_cout)
    );

    opnd_amt_decode #(
        .DATA_W   (DATA_W),
        .SHAMT_W  (SHAMT_W),
        .RS_AMT_W (RS_AMT_W)
    ) u_dec (
        .is_reg    (form == FORM_REG_SHIFT),
        .kind      (kind),
        .imm_shamt (imm_shamt),
        .rs_low    (rs_val[RS_AMT_W-1:0]),
        .amt_class (amt_class),
        .amt       (amt)
    );

    opnd_barrel #(
        .DATA_W (DATA_W)
    ) u_sh (
        .kind      (kind),
        .amt_class (amt_class),
        .amt       (amt),
        .val       (rm_val),
        .carry_in  (carry_in),
        .sh_res    (sh_res),
        .sh_cout   (sh_cout)
    );

    // Choose the operand source by form
    always_comb begin
        case (form)
            FORM_IMM_ROT: begin
                operand_out = rot_res;
                carry_out   = rot_cout;
            end
            FORM_IMM_SHIFT, FORM_REG_SHIFT: begin
                operand_out = sh_res;
                carry_out   = sh_cout;
            end
            default: begin
                operand_out = '0;
                carry_out   = carry_in;
            end
        endcase
    end

endmodule

// File: rtl/opnd_shift_unit_chk.sv
// Checker for opnd_shift_unit: relates the outputs to the inputs for the
// special encodings. Combinational block, so the checks are immediate.
module opnd_shift_unit_chk #(
    parameter int DATA_W   = 32,
    parameter int IMM_W    = 8,
    parameter int ROT_W    = 4,
    parameter int RS_AMT_W = 8
) (
    input logic [1:0]                form_sel,
    input logic [1:0]                shift_kind,
    input logic [IMM_W-1:0]          imm_byte,
    input logic [ROT_W-1:0]          imm_rot,
    input logic [$clog2(DATA_W)-1:0] imm_shamt,
    input logic [DATA_W-1:0]         rm_val,
    input logic [DATA_W-1:0]         rs_val,
    input logic                      carry_in,
    input logic [DATA_W-1:0]         operand_out,
    input logic                      carry_out
);

    localparam int MSB = DATA_W - 1;
    localparam logic [RS_AMT_W-1:0] FULL_AMT = RS_AMT_W'(DATA_W);

    logic [RS_AMT_W-1:0] rs_amt;
    assign rs_amt = rs_val[RS_AMT_W-1:0];

    // Output checks for the special encodings
    always_comb begin
        if (form_sel == 2'b00 && imm_rot == '0) begin
            a_r2_zero_rot_keeps_flag: assert (carry_out == carry_in &&
                operand_out == DATA_W'(imm_byte))
                else $error("a_r2_zero_rot_keeps_flag");
        end
        if (form_sel == 2'b01 && imm_shamt == '0 && shift_kind == 2'b01) begin
            a_r5_lsr_zero_is_full: assert (operand_out == '0 && carry_out == rm_val[MSB])
                else $error("a_r5_lsr_zero_is_full");
        end
        if (form_sel == 2'b01 && imm_shamt == '0 && shift_kind == 2'b11) begin
            a_r7_rrx: assert (operand_out == {carry_in, rm_val[MSB:1]} &&
                carry_out == rm_val[0])
                else $error("a_r7_rrx");
        end
        if (form_sel == 2'b10 && rs_amt == '0) begin
            a_r8_reg_zero_pass: assert (operand_out == rm_val && carry_out == carry_in)
                else $error("a_r8_reg_zero_pass");
        end
        if (form_sel == 2'b10 && shift_kind == 2'b01 && rs_amt > FULL_AMT) begin
            a_r10_lsr_beyond_zero: assert (operand_out == '0 && carry_out == 1'b0)
                else $error("a_r10_lsr_beyond_zero");
        end
        if (form_sel == 2'b10 && shift_kind == 2'b10 && rs_amt >= FULL_AMT) begin
            a_r11_asr_sign_fill: assert (operand_out == {DATA_W{rm_val[MSB]}} &&
                carry_out == rm_val[MSB])
                else $error("a_r11_asr_sign_fill");
        end
        if (form_sel == 2'b11) begin
            a_r13_unused_form: assert (operand_out == '0 && carry_out == carry_in)
                else $error("a_r13_unused_form");
        end
    end

endmodule

bind opnd_shift_unit opnd_shift_unit_chk #(
    .DATA_W   (DATA_W),
    .IMM_W    (IMM_W),
    .ROT_W    (ROT_W),
    .RS_AMT_W (RS_AMT_W)
) u_chk (
    .form_sel    (form_sel),
    .shift_kind  (shift_kind),
    .imm_byte    (imm_byte),
    .imm_rot     (imm_rot),
    .imm_shamt   (imm_shamt),
    .rm_val      (rm_val),
    .rs_val      (rs_val),
    .carry_in    (carry_in),
    .operand_out (operand_out),
    .carry_out   (carry_out)
);

// File: tb/sim_opnd_shift_unit.sv
module sim_opnd_shift_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  form_sel;
    logic [1:0]  shift_kind;
    logic [7:0]  imm_byte;
    logic [3:0]  imm_rot;
    logic [4:0]  imm_shamt;
    logic [31:0] rm_val;
    logic [31:0] rs_val;
    logic        carry_in;
    logic [31:0] operand_out;
    logic        carry_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    opnd_shift_unit u0 (
        .form_sel    (form_sel),
        .shift_kind  (shift_kind),
        .imm_byte    (imm_byte),
        .imm_rot     (imm_rot),
        .imm_shamt   (imm_shamt),
        .rm_val      (rm_val),
        .rs_val      (rs_val),
        .carry_in    (carry_in),
        .operand_out (operand_out),
        .carry_out   (carry_out)
    );

    typedef struct packed {
        logic [1:0]  form;
        logic [1:0]  kind;
        logic [7:0]  imm;
        logic [3:0]  rot;
        logic [4:0]  sh;
        logic [31:0] rm;
        logic [31:0] rs;
        logic        cin;
        logic [31:0] eop;
        logic        ec;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 2'd0, 8'hFF, 4'd4, 5'd0, 32'h0, 32'h0, 1'b0, 32'hFF000000, 1'b1, 8'd1},  // R1
        '{2'd0, 2'd0, 8'hAB, 4'd0, 5'd0, 32'h0, 32'h0, 1'b1, 32'h000000AB, 1'b1, 8'd2},  // R2
        '{2'd0, 2'd0, 8'h01, 4'd1, 5'd0, 32'h0, 32'h0, 1'b1, 32'h40000000, 1'b0, 8'd2},  // R2
        '{2'd1, 2'd0, 8'h0, 4'd0, 5'd4, 32'hF0000001, 32'h0, 1'b0, 32'h00000010, 1'b1, 8'd3}, // R3
        '{2'd1, 2'd1, 8'h0, 4'd0, 5'd1, 32'h00000003, 32'h0, 1'b0, 32'h00000001, 1'b1, 8'd3}, // R3
        '{2'd1, 2'd2, 8'h0, 4'd0, 5'd4, 32'h80000008, 32'h0, 1'b0, 32'hF8000000, 1'b1, 8'd3}, // R3
        '{2'd1, 2'd3, 8'h0, 4'd0, 5'd8, 32'h12345678, 32'h0, 1'b1, 32'h78123456, 1'b0, 8'd3}, // R3
        '{2'd1, 2'd0, 8'h0, 4'd0, 5'd0, 32'hDEADBEEF, 32'h0, 1'b1, 32'hDEADBEEF, 1'b1, 8'd4}, // R4
        '{2'd1, 2'd1, 8'h0, 4'd0, 5'd0, 32'h80000000, 32'h0, 1'b0, 32'h00000000, 1'b1, 8'd5}, // R5
        '{2'd1, 2'd2, 8'h0, 4'd0, 5'd0, 32'h7FFFFFFF, 32'h0, 1'b1, 32'h00000000, 1'b0, 8'd6}, // R6
        '{2'd1, 2'd2, 8'h0, 4'd0, 5'd0, 32'h80000001, 32'h0, 1'b0, 32'hFFFFFFFF, 1'b1, 8'd6}, // R6
        '{2'd1, 2'd3, 8'h0, 4'd0, 5'd0, 32'h00000003, 32'h0, 1'b1, 32'h80000001, 1'b1, 8'd7}, // R7
        '{2'd2, 2'd0, 8'h0, 4'd0, 5'd0, 32'h12345678, 32'hFFFFFF00, 1'b0, 32'h12345678, 1'b0, 8'd8}, // R8
        '{2'd2, 2'd0, 8'h0, 4'd0, 5'd0, 32'h00000001, 32'h00000120, 1'b0, 32'h00000000, 1'b1, 8'd9}, // R9
        '{2'd2, 2'd0, 8'h0, 4'd0, 5'd0, 32'hFFFFFFFF, 32'h00000021, 1'b1, 32'h00000000, 1'b0, 8'd9}, // R9
        '{2'd2, 2'd0, 8'h0, 4'd0, 5'd0, 32'hF0000001, 32'h00000F04, 1'b0, 32'h00000010, 1'b1, 8'd8}, // R8
        '{2'd2, 2'd1, 8'h0, 4'd0, 5'd0, 32'h80000000, 32'h00000020, 1'b0, 32'h00000000, 1'b1, 8'd10}, // R10
        '{2'd2, 2'd1, 8'h0, 4'd0, 5'd0, 32'hFFFFFFFF, 32'h000000FF, 1'b1, 32'h00000000, 1'b0, 8'd10}, // R10
        '{2'd2, 2'd2, 8'h0, 4'd0, 5'd0, 32'h80000000, 32'h00000040, 1'b0, 32'hFFFFFFFF, 1'b1, 8'd11}, // R11
        '{2'd2, 2'd2, 8'h0, 4'd0, 5'd0, 32'h80000000, 32'h00000010, 1'b1, 32'hFFFF8000, 1'b0, 8'd11}, // R11
        '{2'd2, 2'd3, 8'h0, 4'd0, 5'd0, 32'h80000001, 32'h00000020, 1'b0, 32'h80000001, 1'b1, 8'd12}, // R12
        '{2'd2, 2'd3, 8'h0, 4'd0, 5'd0, 32'h0000000F, 32'h00000024, 1'b0, 32'hF0000000, 1'b1, 8'd12}, // R12
        '{2'd3, 2'd1, 8'h55, 4'd3, 5'd7, 32'hFFFFFFFF, 32'h1, 1'b1, 32'h00000000, 1'b1, 8'd13}  // R13
    };

    // Arithmetic model of a shift by amount a (0..255) of the given kind
    function automatic logic [32:0] ref_shift(input logic [1:0] k, input int a,
                                              input logic [31:0] rm, input logic cin);
        logic [63:0] w;
        int          r;
        if (a == 0) return {cin, rm};
        case (k)
            2'd0: begin
                w = {32'b0, rm} << a;
                return {w[32], w[31:0]};
            end
            2'd1: begin
                w = {rm, 32'b0} >> a;
                return {w[31], w[63:32]};
            end
            2'd2: begin
                w = $signed({rm, 32'b0}) >>> ((a > 32) ? 32 : a);
                return {w[31], w[63:32]};
            end
            default: begin
                r = a % 32;
                if (r == 0) return {rm[31], rm};
                w = {rm, rm} >> r;
                return {w[31], w[31:0]};
            end
        endcase
    endfunction

    task automatic drive(input logic [1:0] f, input logic [1:0] k, input logic [7:0] ib,
                         input logic [3:0] ro, input logic [4:0] sh, input logic [31:0] rm,
                         input logic [31:0] rs, input logic cin);
        @(negedge clk);
        form_sel = f; shift_kind = k; imm_byte = ib; imm_rot = ro;
        imm_shamt = sh; rm_val = rm; rs_val = rs; carry_in = cin;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] eop, input logic ec);
        checks++;
        if (operand_out !== eop || carry_out !== ec) begin
            errors++;
            $display("FAIL %s: got operand=%h carry=%b, expected operand=%h carry=%b",
                     tag, operand_out, carry_out, eop, ec);
        end
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [32:0] e;
        form_sel = 2'd0; shift_kind = 2'd0; imm_byte = 8'h0; imm_rot = 4'd0;
        imm_shamt = 5'd0; rm_val = 32'h0; rs_val = 32'h0; carry_in = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 idle", 32'h0, 1'b0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].form, VECS[i].kind, VECS[i].imm, VECS[i].rot, VECS[i].sh,
                  VECS[i].rm, VECS[i].rs, VECS[i].cin);
            check($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].eop, VECS[i].ec);
        end

        // R1 R2: every rotate amount of a one-bit constant
        for (int r = 0; r < 16; r++) begin
            logic [31:0] exp_v;
            exp_v = (r == 0) ? 32'h80 : (32'h80 >> (2 * r)) | (32'h80 << (32 - 2 * r));
            drive(2'd0, 2'd0, 8'h80, 4'(r), 5'd0, 32'h0, 32'h0, 1'b1);
            check("R1 R2 rotate sweep", exp_v, (r == 0) ? 1'b1 : exp_v[31]);
        end

        // R8 R9 R10 R11 R12: register amounts 0..40 and 255, all kinds
        for (int k = 0; k < 4; k++) begin
            for (int a = 0; a <= 41; a++) begin
                for (int p = 0; p < 3; p++) begin
                    logic [31:0] rmv;
                    int          amtv;
                    amtv = (a == 41) ? 255 : a;
                    rmv  = (p == 0) ? 32'h80000001 : (p == 1) ? 32'h6DB6DB6D : 32'hFFFF0000;
                    e = ref_shift(2'(k), amtv, rmv, p[0]);
                    drive(2'd2, 2'(k), 8'h0, 4'd0, 5'd0, rmv, {24'hA5A5A5, 8'(amtv)}, p[0]);
                    check($sformatf("R8/R12 reg kind%0d amt%0d", k, amtv), e[31:0], e[32]);
                end
            end
        end

        // R3 R4 R5 R6 R7: immediate amounts 0..31, all kinds
        for (int k = 0; k < 4; k++) begin
            for (int a = 0; a < 32; a++) begin
                logic [31:0] rmv;
                rmv = 32'hC3A50F81;
                if (a != 0)       e = ref_shift(2'(k), a, rmv, 1'b1);
                else if (k == 0)  e = {1'b1, rmv};
                else if (k == 3)  e = {rmv[0], 1'b1, rmv[31:1]};
                else              e = ref_shift(2'(k), 32, rmv, 1'b1);
                drive(2'd1, 2'(k), 8'h0, 4'd0, 5'(a), rmv, 32'h0, 1'b1);
                check($sformatf("R3-sweep kind%0d amt%0d", k, a), e[31:0], e[32]);
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule